// File: doc/BRIEF.md
# Nested Priority Interrupt Vector Controller

This block collects a set of level-sensitive interrupt sources and sorts them into two request classes: a normal class and a fast class. Each source has an enable bit, a class-select bit and a 3-bit urgency level, all written over a simple register bus. Level 0 is the most urgent. Each class drives one request line toward the processor. Each class also has its own vector register and its own in-service register.

Reading a class's vector register returns a pointer. The pointer holds a software-set base value and the number of the winning source. When nesting is enabled for that class, the same read records the winner's level in the class's in-service register. A recorded level masks requests at that level and at every less urgent level. A write of any data to the in-service register retires the single most urgent recorded level, so handlers unwind strictly in order. With nesting disabled, a class ignores levels, picks the lowest-numbered pending source and never records anything. A fast request always hides a normal request.

The bus has combinational read data. A vector read commits its level on the clock edge that ends the read cycle.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, the nesting control (offset 0x00), enables (0x08), class selects (0x0C) and both in-service registers (0x18 normal, 0x1C fast) read 0, and both request outputs are low.
- R2: A vector read (0x10 normal, 0x14 fast) returns bits 31:23 as zero, bits 22:7 as the 16-bit base (offset 0x04), bits 6:2 as the winning source number and bits 1:0 as zero. For example, base 0xABCD with source 8 winning gives 0x0055E6A0.
- R3: With a class's nesting bit clear (bit 0 normal, bit 1 fast of 0x00), the winner is the lowest-numbered enabled pending source of that class, levels are ignored, and a vector read leaves the in-service register unchanged.
- R4: With nesting set, the winner is the eligible source with the most urgent (numerically smallest) level, and a tie goes to the lower source number.
- R5: With nesting set and an eligible source present, a vector read sets the in-service bit whose index equals the winner's level.
- R6: With nesting set, a source is eligible only if its level is strictly smaller than the index of the lowest set in-service bit (any level when none is set). The class request is high exactly when an eligible source exists.
- R7: Any write to an in-service register clears only its lowest set bit, whatever the data; 0x09 becomes 0x08 after one write and then 0x00.
- R8: While the fast request is high, the normal request is held low.
- R9: Class-select bit i = 1 routes source i to the fast class. The two classes keep separate vector and in-service registers.
- R10: A source whose enable bit (0x08, bit i) is 0 never raises a request and is never chosen as a winner.
- R11: Levels are packed eight per word from offset 0x20. Source i uses word 0x20 + 4*(i/8), bits 4*(i%8)+2 down to 4*(i%8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Raw level-sensitive interrupt sources |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for vector commit) |
| bus_rdata | output | 32 | Combinational read data |
| irq_req_o | output | 1 | Normal-class request |
| fiq_req_o | output | 1 | Fast-class request |

## Verification
The bench builds the block at its default of 20 sources. Source s gets level (5s+3) mod 8, so all eight levels occur and several levels are shared, which exercises the tie rule. With that setup, every ordered pair of pending sources can be swept in both the flat and the nested mode, and the expected winner, vector and in-service value are computed arithmetically. Directed sequences then build stacked in-service states to cover same-level blocking, in-order retirement, class routing and fast-over-normal precedence.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int PRIO_W     = 3;
  localparam int NUM_LVL    = 1 << PRIO_W;
  localparam int VEC_IDX_W  = 5;
  localparam int BASE_W     = 16;
  localparam int DATA_W     = 32;
  localparam int NIB_W      = 4;
  localparam int SRC_PER_WD = DATA_W / NIB_W;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_BASE = 'h04;
  localparam int OFF_EN   = 'h08;
  localparam int OFF_CLS  = 'h0C;
  localparam int OFF_VEC  = 'h10;
  localparam int OFF_ISV  = 'h18;
  localparam int OFF_PRIO = 'h20;

  typedef logic [NUM_LVL-1:0] lvl_mask_t;
  typedef logic [PRIO_W-1:0]  prio_t;
  typedef enum logic {CLS_NORM = 1'b0, CLS_FAST = 1'b1} cls_e;

  // Index of the most urgent recorded level, NUM_LVL when none is set.
  function automatic logic [PRIO_W:0] lvl_ceiling(input lvl_mask_t m);
    logic [PRIO_W:0] c;
    c = (PRIO_W+1)'(NUM_LVL);
    for (int i = NUM_LVL-1; i >= 0; i--)
      if (m[i]) c = (PRIO_W+1)'(i);
    return c;
  endfunction

  // Drop the lowest set bit only.
  function automatic lvl_mask_t retire_lowest(input lvl_mask_t m);
    return m & (m - lvl_mask_t'(1));
  endfunction

  function automatic logic [DATA_W-1:0] build_vector(input logic [BASE_W-1:0] b,
                                                     input logic [VEC_IDX_W-1:0] idx);
    return {9'd0, b, idx, 2'b00};
  endfunction
endpackage

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [1:0]                nest_en,
  output logic [BASE_W-1:0]         base,
  output logic [NUM_SRC-1:0]        src_en,
  output logic [NUM_SRC-1:0]        src_cls,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nest_en <= '0;
      base    <= '0;
      src_en  <= '0;
      src_cls <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFF_CTRL)) nest_en <= wdata[1:0];
      if (addr == ADDR_W'(OFF_BASE)) base    <= wdata[BASE_W-1:0];
      if (addr == ADDR_W'(OFF_EN))   src_en  <= wdata[NUM_SRC-1:0];
      if (addr == ADDR_W'(OFF_CLS))  src_cls <= wdata[NUM_SRC-1:0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    localparam int WORD_ADDR = OFF_PRIO + 4 * (i / SRC_PER_WD);
    localparam int LSB       = NIB_W * (i % SRC_PER_WD);
    prio_t lvl_q;
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else if (wr_en && addr == ADDR_W'(WORD_ADDR)) lvl_q <= wdata[LSB +: PRIO_W];
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = lvl_q;
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 20
) (
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic                      nest_en,
  input  lvl_mask_t                 insvc,
  output logic [NUM_SRC-1:0]        elig,
  output logic                      any,
  output logic [VEC_IDX_W-1:0]      win_idx,
  output prio_t                     win_prio
);
  logic [PRIO_W:0] ceil_lvl;
  prio_t           p;

  assign ceil_lvl = lvl_ceiling(insvc);

  always_comb begin
    elig     = '0;
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    p        = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      p       = prio_flat[i*PRIO_W +: PRIO_W];
      elig[i] = pend[i] && (!nest_en || ({1'b0, p} < ceil_lvl));
      if (elig[i] && (!any || (nest_en && p < win_prio))) begin
        any      = 1'b1;
        win_idx  = VEC_IDX_W'(i);
        win_prio = p;
      end
    end
  end
endmodule

// File: rtl/nic_insvc.sv
module nic_insvc
  import nic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit,
  input  prio_t     commit_lvl,
  input  logic      retire,
  output lvl_mask_t insvc
);
  lvl_mask_t after_retire;
  lvl_mask_t add_bit;

  assign after_retire = retire ? retire_lowest(insvc) : insvc;
  assign add_bit      = commit ? (lvl_mask_t'(1) << commit_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) insvc <= '0;
    else        insvc <= after_retire | add_bit;
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic               irq_req_o,
  output logic               fiq_req_o
);
  localparam int NUM_CLS = 2;

  logic [1:0]                nest_en;
  logic [BASE_W-1:0]         base;
  logic [NUM_SRC-1:0]        src_en;
  logic [NUM_SRC-1:0]        src_cls;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  logic [NUM_CLS-1:0]        cls_any;
  logic [NUM_CLS-1:0]        cls_commit;
  logic [NUM_CLS-1:0]        cls_retire;
  logic [VEC_IDX_W-1:0]      cls_idx  [NUM_CLS];
  prio_t                     cls_prio [NUM_CLS];
  lvl_mask_t                 cls_isv  [NUM_CLS];
  logic [DATA_W-1:0]         cls_vec  [NUM_CLS];

  nic_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .nest_en(nest_en), .base(base), .src_en(src_en), .src_cls(src_cls),
    .prio_flat(prio_flat)
  );

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] elig;
    assign pend = src_i & src_en & (g == int'(CLS_FAST) ? src_cls : ~src_cls);

    nic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .pend(pend), .prio_flat(prio_flat), .nest_en(nest_en[g]), .insvc(cls_isv[g]),
      .elig(elig), .any(cls_any[g]), .win_idx(cls_idx[g]), .win_prio(cls_prio[g])
    );

    assign cls_commit[g] = bus_rd && (bus_addr == ADDR_W'(OFF_VEC + 4*g))
                           && nest_en[g] && cls_any[g];
    assign cls_retire[g] = bus_wr && (bus_addr == ADDR_W'(OFF_ISV + 4*g));

    nic_insvc u_isv (
      .clk(clk), .rst_n(rst_n), .commit(cls_commit[g]), .commit_lvl(cls_prio[g]),
      .retire(cls_retire[g]), .insvc(cls_isv[g])
    );

    assign cls_vec[g] = build_vector(base, cls_any[g] ? cls_idx[g] : '0);
  end

  // Named events for the checker.
  lvl_mask_t isv_irq, isv_fiq;
  logic      commit_irq, commit_fiq, retire_irq, retire_fiq;
  prio_t     win_prio_irq, win_prio_fiq;
  assign isv_irq      = cls_isv[0];
  assign isv_fiq      = cls_isv[1];
  assign commit_irq   = cls_commit[0];
  assign commit_fiq   = cls_commit[1];
  assign retire_irq   = cls_retire[0];
  assign retire_fiq   = cls_retire[1];
  assign win_prio_irq = cls_prio[0];
  assign win_prio_fiq = cls_prio[1];

  assign fiq_req_o = cls_any[1];
  assign irq_req_o = cls_any[0] & ~cls_any[1];

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == ADDR_W'(OFF_CTRL))  bus_rdata[1:0]         = nest_en;
    else if (bus_addr == ADDR_W'(OFF_BASE))  bus_rdata[BASE_W-1:0]  = base;
    else if (bus_addr == ADDR_W'(OFF_EN))    bus_rdata[NUM_SRC-1:0] = src_en;
    else if (bus_addr == ADDR_W'(OFF_CLS))   bus_rdata[NUM_SRC-1:0] = src_cls;
    else if (bus_addr == ADDR_W'(OFF_VEC))   bus_rdata = cls_vec[0];
    else if (bus_addr == ADDR_W'(OFF_VEC+4)) bus_rdata = cls_vec[1];
    else if (bus_addr == ADDR_W'(OFF_ISV))   bus_rdata[NUM_LVL-1:0] = cls_isv[0];
    else if (bus_addr == ADDR_W'(OFF_ISV+4)) bus_rdata[NUM_LVL-1:0] = cls_isv[1];
    else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (bus_addr == ADDR_W'(OFF_PRIO + 4*(i/SRC_PER_WD)))
          bus_rdata[NIB_W*(i%SRC_PER_WD) +: PRIO_W] = prio_flat[i*PRIO_W +: PRIO_W];
    end
  end
endmodule

// File: rtl/nic_chk.sv
module nic_chk
  import nic_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      irq_req_o,
  input logic      fiq_req_o,
  input logic [1:0] nest_en,
  input lvl_mask_t isv_irq,
  input lvl_mask_t isv_fiq,
  input logic      commit_irq,
  input logic      commit_fiq,
  input logic      retire_irq,
  input logic      retire_fiq,
  input prio_t     win_prio_irq,
  input prio_t     win_prio_fiq
);
  assert_fast_hides_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req_o |-> !irq_req_o);

  assert_retire_one_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_irq && !commit_irq && isv_irq != '0) |=>
      ($countones(isv_irq) == $countones($past(isv_irq)) - 1) &&
      ((isv_irq & ~$past(isv_irq)) == '0));

  assert_retire_one_fiq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_fiq && !commit_fiq && isv_fiq != '0) |=>
      ($countones(isv_fiq) == $countones($past(isv_fiq)) - 1));

  assert_commit_sets_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_irq |=> isv_irq[$past(win_prio_irq)]);

  assert_commit_sets_fiq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fiq |=> isv_fiq[$past(win_prio_fiq)]);

  assert_flat_keeps_isv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en[0] && !retire_irq) |=> $stable(isv_irq));

  assert_commit_above_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_irq |-> ({1'b0, win_prio_irq} < lvl_ceiling(isv_irq)));
endmodule

bind nest_irq_ctrl nic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req_o(irq_req_o), .fiq_req_o(fiq_req_o),
  .nest_en(nest_en), .isv_irq(isv_irq), .isv_fiq(isv_fiq),
  .commit_irq(commit_irq), .commit_fiq(commit_fiq),
  .retire_irq(retire_irq), .retire_fiq(retire_fiq),
  .win_prio_irq(win_prio_irq), .win_prio_fiq(win_prio_fiq)
);

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_req_o, fiq_req_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl #(.NUM_SRC(NS), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_req_o(irq_req_o), .fiq_req_o(fiq_req_o)
  );

  function automatic int lvl_of(int s);
    return (5*s + 3) % 8;
  endfunction

  function automatic logic [31:0] vec_of(int b, int idx);
    return 32'(b * 128 + idx * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_src(logic [NS-1:0] v);
    @(negedge clk);
    src_i = v;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pw;
    int base;
    base = 'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 irq_req", 32'(irq_req_o), 0);
    check("R1 fiq_req", 32'(fiq_req_o), 0);
    bus_read('h00, d); check("R1 ctrl", d, 0);
    bus_read('h08, d); check("R1 enable", d, 0);
    bus_read('h0C, d); check("R1 class", d, 0);
    bus_read('h18, d); check("R1 isv norm", d, 0);
    bus_read('h1C, d); check("R1 isv fast", d, 0);

    // R11 level packing
    for (int w = 0; w < 3; w++) begin
      pw = '0;
      for (int j = 0; j < 8; j++)
        if (w*8 + j < NS) pw[4*j +: 4] = 4'(lvl_of(w*8 + j));
      bus_write('h20 + 4*w, pw);
      bus_read('h20 + 4*w, d);
      check("R11 level word", d, pw);
    end
    bus_write('h04, 32'(base));
    bus_write('h08, 32'((1 << NS) - 1));

    // R3 flat mode sweep: lowest number wins, no record
    for (int a = 0; a < NS; a++)
      for (int b = 0; b < NS; b++) begin
        set_src(NS'(1) << a | NS'(1) << b);
        check("R3 request", 32'(irq_req_o), 1);
        bus_read('h10, d);
        check("R3 vector", d, vec_of(base, (a < b) ? a : b));
        bus_read('h18, d);
        check("R3 isv unchanged", d, 0);
      end

    // R4/R5/R7 nested sweep
    bus_write('h00, 32'h1);
    for (int a = 0; a < NS; a++)
      for (int b = 0; b < NS; b++) begin
        int w;
        w = (lvl_of(a) < lvl_of(b) || (lvl_of(a) == lvl_of(b) && a <= b)) ? a : b;
        set_src(NS'(1) << a | NS'(1) << b);
        bus_read('h10, d);
        check("R4 winner", d, vec_of(base, w));
        bus_read('h18, d);
        check("R5 record", d, 32'(1 << lvl_of(w)));
        bus_write('h18, 32'hFFFF_FFFF);
        bus_read('h18, d);
        check("R7 retire", d, 0);
      end

    // R2 vector layout with source 8
    bus_write('h00, 32'h0);
    bus_write('h04, 32'hABCD);
    set_src(NS'(1) << 8);
    bus_read('h10, d);
    check("R2 vector layout", d, 32'h0055_E6A0);
    base = 'hABCD;

    // R6 masking and in-order unwinding (levels: s4=7 s0=3 s2=5 s1=0 s8=3)
    bus_write('h00, 32'h1);
    set_src(NS'(1) << 4);
    bus_read('h10, d);
    bus_read('h18, d); check("R5 stack 0x80", d, 32'h80);
    set_src(NS'(1) << 4 | NS'(1) << 0);
    check("R6 more urgent eligible", 32'(irq_req_o), 1);
    bus_read('h10, d); check("R4 vector s0", d, vec_of(base, 0));
    bus_read('h18, d); check("R5 stack 0x88", d, 32'h88);
    set_src(NS'(1) << 4 | NS'(1) << 0 | NS'(1) << 2);
    check("R6 all masked", 32'(irq_req_o), 0);
    set_src(NS'(1) << 8);
    check("R6 equal level masked", 32'(irq_req_o), 0);
    bus_write('h00, 32'h0);
    #1 check("R3 flat ignores record", 32'(irq_req_o), 1);
    bus_write('h00, 32'h1);
    set_src(NS'(1) << 2);
    check("R6 blocked before retire", 32'(irq_req_o), 0);
    bus_write('h18, 32'h0);
    bus_read('h18, d); check("R7 retire to 0x80", d, 32'h80);
    check("R6 unmasked after retire", 32'(irq_req_o), 1);
    bus_write('h18, 32'h0);
    // 0x09 example
    set_src(NS'(1) << 0);
    bus_read('h10, d);
    set_src(NS'(1) << 1);
    bus_read('h10, d);
    bus_read('h18, d); check("R5 stack 0x09", d, 32'h09);
    bus_write('h18, 32'hFF);
    bus_read('h18, d); check("R7 0x09 to 0x08", d, 32'h08);
    bus_write('h18, 32'hFF);
    bus_read('h18, d); check("R7 0x08 to 0x00", d, 32'h00);

    // R10 disabled source
    bus_write('h08, 32'((1 << NS) - 1) & ~32'(1 << 2));
    set_src(NS'(1) << 2);
    check("R10 no request", 32'(irq_req_o), 0);
    bus_read('h10, d);
    bus_read('h18, d); check("R10 no record", d, 0);
    bus_write('h08, 32'((1 << NS) - 1));

    // R8/R9 class routing (s4 level 7 and s10 level 5 are fast)
    bus_write('h00, 32'h0);
    bus_write('h0C, 32'(1 << 4 | 1 << 10));
    set_src(NS'(1) << 2 | NS'(1) << 4);
    check("R8 fast high", 32'(fiq_req_o), 1);
    check("R8 normal hidden", 32'(irq_req_o), 0);
    bus_read('h14, d); check("R9 fast vector", d, vec_of(base, 4));
    bus_read('h10, d); check("R9 normal vector", d, vec_of(base, 2));
    bus_write('h00, 32'h3);
    bus_read('h14, d);
    bus_read('h1C, d); check("R9 fast record", d, 32'h80);
    bus_read('h18, d); check("R9 normal record separate", d, 0);
    check("R6 fast masked", 32'(fiq_req_o), 0);
    check("R8 normal released", 32'(irq_req_o), 1);
    set_src(NS'(1) << 2 | NS'(1) << 4 | NS'(1) << 10);
    check("R6 fast more urgent", 32'(fiq_req_o), 1);
    check("R8 normal hidden again", 32'(irq_req_o), 0);
    bus_write('h1C, 32'h0);
    bus_read('h1C, d); check("R7 fast retire", d, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule